// File: doc/BRIEF.md
# Pulse-Position Word Validator with Repeat Confirmation

This block sits behind an interval classifier in a pulse-position remote-control receiver. The classifier reports one symbol for each measured gap between pulses. A symbol is a zero bit, a one bit, a word gap, a guard violation or a timeout. The validator shifts the bit symbols into a word register and closes a frame on each word gap. A frame is valid only if exactly five bits arrived since the previous boundary, which means six pulses. The block acts on a code only when two valid frames in a row carry the same five bits.

Once a code is confirmed, the block raises a ready flag and presents the 5-bit word (bits e..a, with a in bit 0). It also gives a single-cycle strobe for the new acceptance. The flag stays high while the transmitter keeps repeating the same code. A timeout drops the flag. So does a valid frame that carries a different code. Downstream logic uses the strobe to act once per key press and uses the flag for continuous or held responses.

Top module: `ppmv_validator`

## Requirements
- R1: After a synchronous reset, `word_ready` is 0, `word_new` is 0 and `word_out` is 0.
- R2: Bits are shifted in so that the first bit symbol of a frame lands in `word_out[0]` (bit a) and the fifth lands in `word_out[4]` (bit e). Code 0 is a zero bit and code 1 is a one bit.
- R3: A word gap (code 2) that closes a frame of exactly five bits marks a valid frame. `word_ready` rises one clock after a valid frame that equals the valid frame just before it, with no rejected frame, guard violation or timeout between them. `word_out` then shows that word.
- R4: `word_new` is high for exactly one cycle per acceptance, in the cycle `word_ready` first shows the accepted word. Further identical valid frames while ready produce no strobe.
- R5: While `word_ready` is high, identical valid frames keep it high, and `word_out` changes only in a cycle where `word_new` is high.
- R6: A word gap that closes a frame with fewer or more than five bits rejects the frame and forgets the stored previous frame. The next valid frame therefore cannot complete a pair.
- R7: A guard violation, meaning code 3 or any of the unused codes 5, 6 and 7, discards the partial frame and forgets the stored previous frame. It leaves `word_ready` and `word_out` unchanged.
- R8: A timeout (code 4) clears `word_ready` on the next clock, discards the partial frame and forgets the stored previous frame.
- R9: A valid frame whose word differs from the accepted word clears `word_ready` on the next clock. That frame becomes the stored previous frame, so one more identical frame re-accepts with a strobe.
- R10: When `sym_valid` is low, `sym_code` is ignored and neither the outputs nor the frame state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power clear) |
| sym_valid | input | 1 | Qualifies `sym_code` for this cycle |
| sym_code | input | 3 | Classified interval symbol (codes as in R2, R3, R7, R8) |
| word_ready | output | 1 | Confirmed code is present and still being repeated |
| word_out | output | WORD_BITS (5) | Last accepted word, bit a at index 0 |
| word_new | output | 1 | One-cycle strobe on each acceptance |

## Verification
The bench builds the block with its default of five bits per word. With only five bits, a small pool of codes can be drawn at random and repeats happen often. Confirmations, redundant repeats and code changes therefore all occur many times in a short run. Frames one bit short and one bit long are generated directly, so the bit counter's underflow and overflow bounds are both reached. Idle cycles placed at random between symbols check that an unqualified code has no effect, even when that code is a gap or a timeout.

// File: rtl/ppmv_pkg.sv
package ppmv_pkg;

    // Symbol codes delivered by the interval classifier
    localparam logic [2:0] CODE_ZERO    = 3'd0;
    localparam logic [2:0] CODE_ONE     = 3'd1;
    localparam logic [2:0] CODE_GAP     = 3'd2;
    localparam logic [2:0] CODE_GUARD   = 3'd3;
    localparam logic [2:0] CODE_TIMEOUT = 3'd4;

    // Internal decoded symbol kind
    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_BIT,
        KIND_GAP,
        KIND_GUARD,
        KIND_EXPIRE
    } sym_kind_e;

    // Events handed from the framer to the repeat checker
    typedef struct packed {
        logic close_ok;   // gap closed a frame of the right length
        logic reject;     // bad frame length or guard violation
        logic expire;     // transmission timed out
    } frame_ev_t;

    function automatic sym_kind_e decode_sym(input logic valid, input logic [2:0] code);
        sym_kind_e k;
        if (!valid) begin
            k = KIND_NONE;
        end else begin
            case (code)
                CODE_ZERO, CODE_ONE: k = KIND_BIT;
                CODE_GAP:            k = KIND_GAP;
                CODE_TIMEOUT:        k = KIND_EXPIRE;
                default:             k = KIND_GUARD;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/ppmv_framer.sv
module ppmv_framer
    import ppmv_pkg::*;
#(
    parameter int WORD_BITS = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sym_valid,
    input  logic [2:0]           sym_code,
    output frame_ev_t            ev,
    output logic [WORD_BITS-1:0] frame_word
);
    localparam int CW = $clog2(WORD_BITS + 2);
    localparam logic [CW-1:0] CNT_FULL = CW'(WORD_BITS);
    localparam logic [CW-1:0] CNT_OVER = CW'(WORD_BITS + 1);

    sym_kind_e            kind;
    logic [CW-1:0]        bit_cnt;
    logic [WORD_BITS-1:0] shreg;

    assign kind = decode_sym(sym_valid, sym_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            case (kind)
                KIND_BIT: begin
                    if (bit_cnt < CNT_FULL) begin
                        // newest bit enters at the top; the first bit ends at index 0
                        shreg   <= {sym_code[0], shreg[WORD_BITS-1:1]};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else begin
                        bit_cnt <= CNT_OVER;
                    end
                end
                KIND_GAP, KIND_GUARD, KIND_EXPIRE: bit_cnt <= '0;
                default: ;
            endcase
        end
    end

    always_comb begin
        ev.close_ok = (kind == KIND_GAP) && (bit_cnt == CNT_FULL);
        ev.reject   = ((kind == KIND_GAP) && (bit_cnt != CNT_FULL)) || (kind == KIND_GUARD);
        ev.expire   = (kind == KIND_EXPIRE);
    end

    assign frame_word = shreg;

endmodule

// File: rtl/ppmv_repeat.sv
module ppmv_repeat
    import ppmv_pkg::*;
#(
    parameter int WORD_BITS = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  frame_ev_t            ev,
    input  logic [WORD_BITS-1:0] frame_word,
    output logic                 ready,
    output logic [WORD_BITS-1:0] acc_word,
    output logic                 new_pulse
);
    logic [WORD_BITS-1:0] prev_word;
    logic                 prev_ok;
    logic                 pair_match;
    logic                 same_as_acc;

    assign pair_match  = prev_ok && (frame_word == prev_word);
    assign same_as_acc = frame_word == acc_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_word <= '0;
            prev_ok   <= 1'b0;
            acc_word  <= '0;
            ready     <= 1'b0;
            new_pulse <= 1'b0;
        end else begin
            new_pulse <= 1'b0;
            if (ev.expire) begin
                ready   <= 1'b0;
                prev_ok <= 1'b0;
            end else if (ev.reject) begin
                prev_ok <= 1'b0;
            end else if (ev.close_ok) begin
                prev_word <= frame_word;
                prev_ok   <= 1'b1;
                if (pair_match && !(ready && same_as_acc)) begin
                    acc_word  <= frame_word;
                    ready     <= 1'b1;
                    new_pulse <= 1'b1;
                end else if (ready && !same_as_acc) begin
                    ready <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/ppmv_validator.sv
module ppmv_validator
    import ppmv_pkg::*;
#(
    parameter int WORD_BITS = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sym_valid,
    input  logic [2:0]           sym_code,
    output logic                 word_ready,
    output logic [WORD_BITS-1:0] word_out,
    output logic                 word_new
);
    frame_ev_t            ev;
    logic [WORD_BITS-1:0] frame_word;

    ppmv_framer #(.WORD_BITS(WORD_BITS)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .sym_valid  (sym_valid),
        .sym_code   (sym_code),
        .ev         (ev),
        .frame_word (frame_word)
    );

    ppmv_repeat #(.WORD_BITS(WORD_BITS)) u_repeat (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .frame_word (frame_word),
        .ready      (word_ready),
        .acc_word   (word_out),
        .new_pulse  (word_new)
    );

endmodule

// File: rtl/ppmv_validator_chk.sv
module ppmv_validator_chk #(
    parameter int WORD_BITS = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 sym_valid,
    input logic [2:0]           sym_code,
    input logic                 word_ready,
    input logic [WORD_BITS-1:0] word_out,
    input logic                 word_new
);
    AST_NEW_WITH_READY: assert property (@(posedge clk) disable iff (rst)
        word_new |-> word_ready);                                            // R4
    AST_NEW_SINGLE: assert property (@(posedge clk) disable iff (rst)
        word_new |=> !word_new);                                             // R4
    AST_READY_RISE_STROBES: assert property (@(posedge clk) disable iff (rst)
        $rose(word_ready) |-> word_new);                                     // R3
    AST_WORD_HELD: assert property (@(posedge clk) disable iff (rst)
        !word_new |-> $stable(word_out));                                    // R5
    AST_TIMEOUT_DROPS: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_code == 3'd4) |=> !word_ready);                    // R8
    AST_IDLE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> ($stable(word_ready) && !word_new));                  // R10
endmodule

bind ppmv_validator ppmv_validator_chk #(.WORD_BITS(WORD_BITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sym_valid  (sym_valid),
    .sym_code   (sym_code),
    .word_ready (word_ready),
    .word_out   (word_out),
    .word_new   (word_new)
);

// File: tb/tb_ppmv_validator.sv
`timescale 1ns/1ps
module tb_ppmv_validator;
    localparam int WB = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sym_valid = 1'b0;
    logic [2:0]    sym_code = 3'd0;
    logic          word_ready;
    logic [WB-1:0] word_out;
    logic          word_new;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state derived from the requirements
    logic [WB-1:0] m_sh, m_prev, m_acc;
    int            m_cnt;
    bit            m_pok, m_rdy, m_new;

    always #10 clk = ~clk;   // 50 MHz

    ppmv_validator #(.WORD_BITS(WB)) dut (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_code(sym_code),
        .word_ready(word_ready), .word_out(word_out), .word_new(word_new)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_sh = '0; m_prev = '0; m_acc = '0; m_cnt = 0;
        m_pok = 0; m_rdy = 0; m_new = 0;
    endfunction

    // reference for R2..R10 applied to one qualified symbol
    function automatic void model_step(input logic [2:0] c);
        m_new = 0;
        case (c)
            3'd0, 3'd1: begin
                if (m_cnt < WB) begin
                    m_sh[m_cnt] = c[0];
                    m_cnt++;
                end else m_cnt = WB + 1;
            end
            3'd2: begin
                if (m_cnt == WB) begin
                    if (m_pok && m_sh == m_prev && !(m_rdy && m_sh == m_acc)) begin
                        m_acc = m_sh; m_rdy = 1; m_new = 1;
                    end else if (m_rdy && m_sh != m_acc) m_rdy = 0;
                    m_prev = m_sh; m_pok = 1;
                end else m_pok = 0;
                m_cnt = 0; m_sh = '0;
            end
            3'd4: begin m_rdy = 0; m_pok = 0; m_cnt = 0; m_sh = '0; end
            default: begin m_pok = 0; m_cnt = 0; m_sh = '0; end
        endcase
    endfunction

    task automatic compare(input string tag);
        chk({tag, " ready"}, word_ready, m_rdy);
        chk({tag, " new"},   word_new,   m_new);
        if (m_rdy) chk({tag, " word"}, word_out, m_acc);
    endtask

    // one qualified symbol, outputs checked after the consuming edge
    task automatic sym(input logic [2:0] c, input string tag);
        @(negedge clk);
        sym_valid = 1'b1; sym_code = c;
        @(negedge clk);
        sym_valid = 1'b0; sym_code = 3'($urandom_range(0, 7));
        model_step(c);
        compare(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sym_valid = 1'b0; sym_code = 3'($urandom_range(0, 7));
            m_new = 0;
            @(negedge clk);
            compare(tag);
        end
    endtask

    task automatic frame(input logic [WB-1:0] w, input int nbits, input string tag);
        for (int i = 0; i < nbits; i++) begin
            sym({2'b00, w[i % WB]}, tag);
            if ($urandom_range(0, 3) == 0) idle(1, "R10");
        end
        sym(3'd2, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        logic [WB-1:0] pool [3];
        void'($urandom(32'd1757));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", word_ready, 0);
        chk("R1 new",   word_new,   0);
        chk("R1 word",  word_out,   0);

        // R2: first bit is bit a
        frame(5'b00001, WB, "R2");
        chk("R3 single frame not ready", word_ready, 0);
        frame(5'b00001, WB, "R2");
        chk("R2 first bit at index 0", word_out, 5'b00001);
        chk("R4 strobe on accept", word_new, 1);
        frame(5'b00001, WB, "R4");
        chk("R4 no strobe on repeat", word_new, 0);
        chk("R5 ready held on repeat", word_ready, 1);

        // R10: gap/timeout codes without valid
        idle(6, "R10");
        chk("R10 ready unchanged", word_ready, 1);

        // R7: guard keeps ready, partial discarded
        sym(3'd1, "R7"); sym(3'd0, "R7"); sym(3'd6, "R7");
        chk("R7 ready kept", word_ready, 1);
        chk("R7 word kept", word_out, 5'b00001);
        // R9: different code drops, its repeat re-accepts
        frame(5'b10110, WB, "R9");
        chk("R9 differing drops ready", word_ready, 0);
        frame(5'b10110, WB, "R9");
        chk("R9 reaccept", word_out, 5'b10110);
        chk("R9 reaccept strobe", word_new, 1);

        // R8 timeout
        sym(3'd4, "R8");
        chk("R8 timeout drops", word_ready, 0);
        frame(5'b10110, WB, "R8");
        chk("R8 previous forgotten", word_ready, 0);

        // R6 short and long frames break the pair
        sym(3'd4, "R6");
        frame(5'b01011, WB, "R6");
        frame(5'b01011, WB - 1, "R6");
        frame(5'b01011, WB, "R6");
        chk("R6 short frame breaks pair", word_ready, 0);
        frame(5'b01011, WB + 1, "R6");
        frame(5'b01011, WB, "R6");
        chk("R6 long frame breaks pair", word_ready, 0);
        frame(5'b01011, WB, "R6");
        chk("R6 pair after recovery", word_ready, 1);

        // R7 guard between frames forgets previous
        sym(3'd4, "R7");
        frame(5'b11100, WB, "R7");
        sym(3'd1, "R7"); sym(3'd3, "R7");
        frame(5'b11100, WB, "R7");
        chk("R7 guard forgets previous", word_ready, 0);

        // R3 constrained random stream
        pool[0] = 5'b10101; pool[1] = 5'b00111; pool[2] = 5'b11000;
        for (int n = 0; n < 400; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 70)      frame(pool[$urandom_range(0, 2)], WB, "R3");
            else if (r < 78) frame(pool[$urandom_range(0, 2)], $urandom_range(0, WB - 1), "R6");
            else if (r < 84) frame(pool[$urandom_range(0, 2)], WB + 1 + $urandom_range(0, 2), "R6");
            else if (r < 92) sym(3'($urandom_range(0, 1) ? 3 : $urandom_range(5, 7)), "R7");
            else if (r < 96) sym(3'd4, "R8");
            else             idle($urandom_range(1, 4), "R10");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule